// File: doc/BRIEF.md
# Coalescing Interrupt Status Controller

This block collects hardware events for a host processor and drives one interrupt line. Events land in two write-one-to-clear status registers. The main register holds a set of direct event sources. The DMA register holds receive, transmit, error and urgent-receive flags from a DMA engine. Three main-status bits do not store anything. Each one shows the OR of a group of DMA-register bits. To clear one of those bits, the host clears the DMA register. An enable mask selects which main-status bits can request an interrupt.

A coalescing timer holds the interrupt line low so that several events can collect before the host is interrupted. The timer interval is programmed in units of 32 pulses of an external microsecond strobe. An urgent-receive flag in the DMA register skips the timer entirely. The host uses a plain 32-bit register port: a write strobe with address and data, and a combinational read data output selected by the same address.

Top module: `irq_coalesce_ctrl`

## Requirements
- R1: After reset, all four registers read 0 and `irq_out` is low.
- R2: A pulse on `main_evt` sets main-status bit b when b is 0, 1, 3, 6, 7, 25, 26 or 28. A pulse at any other position of `main_evt` leaves the main status unchanged.
- R3: Writing to the main status (offset 0x008) clears each stored direct bit that is written as 1. Bits written as 0 keep their value.
- R4: If an event and a write-one-to-clear hit the same bit in the same cycle, the bit ends up set. This holds in both status registers.
- R5: The DMA status (offset 0x010) implements only bits 0, 1, 16, 17, 30 and 31. A pulse on `dma_evt` sets the matching bit. Writing 1 to a bit clears it. Pulses at other positions have no effect.
- R6: Main-status bit 31 reads as the OR of DMA bits 16, 17 and 30. Bit 29 reads as DMA bit 31. Bit 27 reads as the OR of DMA bits 0 and 1. Writing to these three main bits has no effect.
- R7: The enable mask (offset 0x00C) stores only the implemented main bits, which are the direct bits plus 27, 29 and 31. `irq_out` can be high only while (main status AND mask) is nonzero.
- R8: When the interval (offset 0x004) is 0, `irq_out` follows (main status AND mask) being nonzero, in the same cycle the status register updates.
- R9: When the interval is K > 0, the timer starts one clock after a pending enabled event first appears. `irq_out` rises on the clock edge that counts the (32·K)-th `usec_tick` after that start.
- R10: When DMA bit 30 and mask bit 31 are both set, `irq_out` is high at once, whatever the interval. An ordinary receive flag (DMA bit 16) does not skip the timer.
- R11: Once nothing is pending, the timer resets. The next event waits for the full interval again.
- R12: The interval register stores the low CW bits of the written data (8 by default) and reads back zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| main_evt | input | 32 | Direct event pulses, one per main-status bit |
| dma_evt | input | 32 | DMA-engine event pulses, one per DMA-status bit |
| usec_tick | input | 1 | One-cycle pulse per microsecond |
| irq_out | output | 1 | Host interrupt request |

## Verification
The checker tests the following on every cycle:
- The output never rises without an enabled pending bit.
- An event always leaves its bit set, even when a write-one-to-clear hits the same bit.
- A write-one-to-clear empties the bits it targets.
- A zero interval or an enabled urgent-receive flag always forces the output high.

Only the bench scenarios can show:
- The exact tick on which the timer releases the output.
- The restart of the timer after the status is cleared.
- That writes to the summary bits have no effect.
- Which bit positions are implemented, shown by sweeping every event position.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
   // Register byte offsets
   localparam int OFF_INTERVAL = 'h004;
   localparam int OFF_MAIN     = 'h008;
   localparam int OFF_MASK     = 'h00C;
   localparam int OFF_DMA      = 'h010;

   // Main status: directly set bits and summary bits
   localparam logic [31:0] MAIN_DIRECT  = 32'h1600_00CB;
   localparam logic [31:0] MAIN_SUMMARY = 32'hA800_0000;
   localparam logic [31:0] MAIN_IMPL    = MAIN_DIRECT | MAIN_SUMMARY;
   localparam int MAIN_RX_BIT  = 31;
   localparam int MAIN_ERR_BIT = 29;
   localparam int MAIN_TX_BIT  = 27;

   // DMA status groups
   localparam logic [31:0] DMA_IMPL  = 32'hC003_0003;
   localparam logic [31:0] DMA_RX    = 32'h4003_0000;
   localparam logic [31:0] DMA_TX    = 32'h0000_0003;
   localparam int DMA_ERR_BIT   = 31;
   localparam int DMA_URGENT_BIT = 30;
endpackage

// File: rtl/irqc_w1c_bank.sv
module irqc_w1c_bank #(
   parameter int W = 32,
   parameter logic [W-1:0] IMPL = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_i,
   input  logic         clr_en,
   input  logic [W-1:0] clr_bits,
   output logic [W-1:0] q
);
   generate
      if (W < 1) begin : g_bad_width
         $error("irqc_w1c_bank: W must be positive");
      end
      for (genvar i = 0; i < W; i++) begin : g_bit
         if (IMPL[i]) begin : g_flop
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)
                  q[i] <= 1'b0;
               else if (set_i[i])
                  q[i] <= 1'b1;               // set beats clear
               else if (clr_en && clr_bits[i])
                  q[i] <= 1'b0;
            end
         end else begin : g_tie
            assign q[i] = 1'b0;
         end
      end
   endgenerate
endmodule

// File: rtl/irqc_coalesce_timer.sv
module irqc_coalesce_timer #(
   parameter int CW         = 8,
   parameter int UNIT_TICKS = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          pending,
   input  logic          usec_tick,
   input  logic [CW-1:0] interval,
   output logic          release_o
);
   localparam int PW = (UNIT_TICKS > 1) ? $clog2(UNIT_TICKS) : 1;
   localparam logic [PW-1:0] PRE_LAST = PW'(UNIT_TICKS - 1);

   generate
      if (UNIT_TICKS < 2) begin : g_bad_unit
         $error("irqc_coalesce_timer: UNIT_TICKS must be at least 2");
      end
      if (CW < 1 || CW > 16) begin : g_bad_cw
         $error("irqc_coalesce_timer: CW out of range");
      end
   endgenerate

   logic          running_q, expired_q;
   logic [PW-1:0] pre_q;
   logic [CW-1:0] units_q;
   logic [CW:0]   units_inc;

   assign units_inc = {1'b0, units_q} + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         running_q <= 1'b0;
         expired_q <= 1'b0;
         pre_q     <= '0;
         units_q   <= '0;
      end else if (!pending) begin
         running_q <= 1'b0;
         expired_q <= 1'b0;
         pre_q     <= '0;
         units_q   <= '0;
      end else if (!running_q && !expired_q) begin
         running_q <= 1'b1;
         pre_q     <= '0;
         units_q   <= '0;
      end else if (running_q && usec_tick) begin
         if (pre_q == PRE_LAST) begin
            pre_q <= '0;
            if (units_inc >= {1'b0, interval}) begin
               expired_q <= 1'b1;
               running_q <= 1'b0;
            end else begin
               units_q <= units_inc[CW-1:0];
            end
         end else begin
            pre_q <= pre_q + 1'b1;
         end
      end
   end

   assign release_o = expired_q || (interval == '0);
endmodule

// File: rtl/irq_coalesce_ctrl.sv
module irq_coalesce_ctrl #(
   parameter int ADDR_W     = 12,
   parameter int CW         = 8,
   parameter int UNIT_TICKS = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr_en,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic [31:0]       main_evt,
   input  logic [31:0]       dma_evt,
   input  logic              usec_tick,
   output logic              irq_out
);
   import irqc_pkg::*;

   generate
      if (ADDR_W < 5) begin : g_bad_addr
         $error("irq_coalesce_ctrl: ADDR_W too small for register map");
      end
      if (CW > 32) begin : g_bad_cw
         $error("irq_coalesce_ctrl: CW exceeds data width");
      end
   endgenerate

   logic          sel_int, sel_main, sel_mask, sel_dma;
   logic [31:0]   main_direct_q, dma_q, mask_q, main_sum, main_view;
   logic [CW-1:0] interval_q;
   logic          pending, urgent, timer_release;

   assign sel_int  = reg_addr == ADDR_W'(OFF_INTERVAL);
   assign sel_main = reg_addr == ADDR_W'(OFF_MAIN);
   assign sel_mask = reg_addr == ADDR_W'(OFF_MASK);
   assign sel_dma  = reg_addr == ADDR_W'(OFF_DMA);

   irqc_w1c_bank #(.W(32), .IMPL(MAIN_DIRECT)) u_main_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_i    (main_evt & MAIN_DIRECT),
      .clr_en   (reg_wr_en && sel_main),
      .clr_bits (reg_wdata),
      .q        (main_direct_q)
   );

   irqc_w1c_bank #(.W(32), .IMPL(DMA_IMPL)) u_dma_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_i    (dma_evt & DMA_IMPL),
      .clr_en   (reg_wr_en && sel_dma),
      .clr_bits (reg_wdata),
      .q        (dma_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q     <= '0;
         interval_q <= '0;
      end else if (reg_wr_en) begin
         if (sel_mask) mask_q <= reg_wdata & MAIN_IMPL;
         if (sel_int)  interval_q <= reg_wdata[CW-1:0];
      end
   end

   always_comb begin
      main_sum               = '0;
      main_sum[MAIN_RX_BIT]  = |(dma_q & DMA_RX);
      main_sum[MAIN_ERR_BIT] = dma_q[DMA_ERR_BIT];
      main_sum[MAIN_TX_BIT]  = |(dma_q & DMA_TX);
   end

   assign main_view = main_direct_q | main_sum;
   assign pending   = |(main_view & mask_q);
   assign urgent    = dma_q[DMA_URGENT_BIT] && mask_q[MAIN_RX_BIT];

   irqc_coalesce_timer #(.CW(CW), .UNIT_TICKS(UNIT_TICKS)) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .pending   (pending),
      .usec_tick (usec_tick),
      .interval  (interval_q),
      .release_o (timer_release)
   );

   assign irq_out = pending && (timer_release || urgent);

   always_comb begin
      reg_rdata = '0;
      if (sel_int)  reg_rdata = 32'(interval_q);
      if (sel_main) reg_rdata = main_view;
      if (sel_mask) reg_rdata = mask_q;
      if (sel_dma)  reg_rdata = dma_q;
   end
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
   parameter int ADDR_W = 12,
   parameter int CW     = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr_en,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [31:0]       reg_wdata,
   input logic [31:0]       main_evt,
   input logic [31:0]       dma_evt,
   input logic              irq_out,
   input logic [31:0]       main_raw,
   input logic [31:0]       main_view,
   input logic [31:0]       dma_raw,
   input logic [31:0]       mask_q,
   input logic [CW-1:0]     interval_q
);
   import irqc_pkg::*;

   assert_irq_needs_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out |-> ((main_view & mask_q) != 32'h0));

   assert_main_set_sticks_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ((main_evt & MAIN_DIRECT) != 32'h0) |=>
         ((main_raw & $past(main_evt & MAIN_DIRECT)) == $past(main_evt & MAIN_DIRECT)));

   assert_dma_set_sticks_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ((dma_evt & DMA_IMPL) != 32'h0) |=>
         ((dma_raw & $past(dma_evt & DMA_IMPL)) == $past(dma_evt & DMA_IMPL)));

   assert_main_w1c_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr_en && reg_addr == ADDR_W'(OFF_MAIN)) |=>
         ((main_raw & $past(reg_wdata & ~main_evt)) == 32'h0));

   assert_zero_interval_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (interval_q == '0 && (main_view & mask_q) != 32'h0) |-> irq_out);

   assert_urgent_bypass_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_raw[DMA_URGENT_BIT] && mask_q[MAIN_RX_BIT]) |-> irq_out);
endmodule

bind irq_coalesce_ctrl irqc_checker #(.ADDR_W(ADDR_W), .CW(CW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .reg_wr_en  (reg_wr_en),
   .reg_addr   (reg_addr),
   .reg_wdata  (reg_wdata),
   .main_evt   (main_evt),
   .dma_evt    (dma_evt),
   .irq_out    (irq_out),
   .main_raw   (main_direct_q),
   .main_view  (main_view),
   .dma_raw    (dma_q),
   .mask_q     (mask_q),
   .interval_q (interval_q)
);

// File: tb/irq_coalesce_ctrl_test.sv
module irq_coalesce_ctrl_test;
   localparam int AW = 12;
   localparam logic [31:0] DIRECT = 32'h1600_00CB;
   localparam logic [31:0] DIMPL  = 32'hC003_0003;
   localparam logic [31:0] MIMPL  = 32'hBE00_00CB;

   logic          clk = 1'b0, rst_n = 1'b0;
   logic          reg_wr_en = 1'b0, usec_tick = 1'b0;
   logic [AW-1:0] reg_addr = '0;
   logic [31:0]   reg_wdata = '0, main_evt = '0, dma_evt = '0;
   logic [31:0]   reg_rdata;
   logic          irq_out;
   int n_chk = 0, n_bad = 0;
   bit done = 0;

   always #5 clk = ~clk;

   irq_coalesce_ctrl #(.ADDR_W(AW)) uut (
      .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .main_evt(main_evt),
      .dma_evt(dma_evt), .usec_tick(usec_tick), .irq_out(irq_out));

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic cyc(); @(negedge clk); endtask

   task automatic wr(int a, logic [31:0] d);
      reg_wr_en = 1'b1; reg_addr = AW'(a); reg_wdata = d;
      cyc();
      reg_wr_en = 1'b0;
   endtask

   task automatic rd(int a, output logic [31:0] d);
      reg_addr = AW'(a); #1; d = reg_rdata;
   endtask

   task automatic ticks(int n);
      usec_tick = 1'b1;
      repeat (n) cyc();
      usec_tick = 1'b0;
   endtask

   function automatic logic [31:0] sum_of(logic [31:0] d);
      logic [31:0] s = '0;
      s[31] = d[16] | d[17] | d[30];
      s[29] = d[31];
      s[27] = d[0] | d[1];
      return s;
   endfunction

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_bad++; n_chk++;
         $display("FAIL watchdog actual=%h expected=%h", 0, 1);
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin : main
      logic [31:0] v;
      cyc(); cyc(); rst_n = 1'b1; cyc();
      // R1 reset state
      rd('h004, v); chk("R1 interval", v, 0);
      rd('h008, v); chk("R1 main", v, 0);
      rd('h00C, v); chk("R1 mask", v, 0);
      rd('h010, v); chk("R1 dma", v, 0);
      chk("R1 irq", {31'b0, irq_out}, 0);

      // R12 interval width, R7 mask implemented bits
      wr('h004, 32'hFFFF_FFFF); rd('h004, v); chk("R12 interval", v, 32'hFF);
      wr('h004, 0);
      wr('h00C, 32'hFFFF_FFFF); rd('h00C, v); chk("R7 mask impl", v, MIMPL);

      // R2, R8, R3 sweep of direct event positions
      for (int b = 0; b < 32; b++) begin
         main_evt = 32'h1 << b; cyc(); main_evt = '0;
         rd('h008, v); chk("R2 main set", v, (32'h1 << b) & DIRECT);
         chk("R8 irq zero interval", {31'b0, irq_out},
             {31'b0, (((32'h1 << b) & DIRECT) != 0)});
         wr('h008, 32'h0); rd('h008, v); chk("R3 write zero keeps", v, (32'h1 << b) & DIRECT);
         wr('h008, 32'hFFFF_FFFF); rd('h008, v); chk("R3 w1c", v, 0);
      end

      // R5, R6 sweep of DMA event positions
      wr('h00C, 0);
      for (int b = 0; b < 32; b++) begin
         dma_evt = 32'h1 << b; cyc(); dma_evt = '0;
         rd('h010, v); chk("R5 dma set", v, (32'h1 << b) & DIMPL);
         rd('h008, v); chk("R6 summary", v, sum_of((32'h1 << b) & DIMPL));
         wr('h008, 32'hFFFF_FFFF);
         rd('h008, v); chk("R6 summary not writable", v, sum_of((32'h1 << b) & DIMPL));
         wr('h010, 32'hFFFF_FFFF); rd('h010, v); chk("R5 dma w1c", v, 0);
      end

      // R4 set wins against clear in the same cycle
      main_evt = 32'h8; dma_evt = 32'h1;
      wr('h008, 32'hFFFF_FFFF);
      main_evt = '0; dma_evt = '0;
      rd('h008, v); chk("R4 main set wins", v, 32'h8 | sum_of(32'h1));
      dma_evt = 32'h1;
      wr('h010, 32'hFFFF_FFFF);
      dma_evt = '0;
      rd('h010, v); chk("R4 dma set wins", v, 32'h1);
      wr('h010, 32'hFFFF_FFFF); wr('h008, 32'hFFFF_FFFF);

      // R7 mask gating
      main_evt = 32'h1; cyc(); main_evt = '0;
      chk("R7 masked irq low", {31'b0, irq_out}, 0);
      wr('h00C, 32'h1);
      chk("R7 enabled irq high", {31'b0, irq_out}, 1);
      wr('h008, 32'hFFFF_FFFF); cyc();
      wr('h00C, 32'hFFFF_FFFF);

      // R9, R11 timer delay, repeated to show restart
      for (int k = 1; k <= 3; k++) begin
         wr('h004, k);
         for (int rep = 0; rep < 2; rep++) begin
            main_evt = 32'h1; cyc(); main_evt = '0;
            cyc();
            chk("R9 held after event", {31'b0, irq_out}, 0);
            ticks(32 * k - 1);
            chk("R9 held before last tick", {31'b0, irq_out}, 0);
            ticks(1);
            chk(rep == 0 ? "R9 released" : "R11 released after restart",
                {31'b0, irq_out}, 1);
            wr('h008, 32'hFFFF_FFFF);
            chk("R11 low after clear", {31'b0, irq_out}, 0);
            cyc();
         end
      end

      // R10 urgent receive bypass
      wr('h004, 4);
      dma_evt = 32'h4000_0000; cyc(); dma_evt = '0;
      chk("R10 urgent bypass", {31'b0, irq_out}, 1);
      wr('h010, 32'hFFFF_FFFF); cyc();
      dma_evt = 32'h0001_0000; cyc(); dma_evt = '0;
      chk("R10 plain rx waits", {31'b0, irq_out}, 0);
      wr('h010, 32'hFFFF_FFFF); cyc();
      wr('h00C, 32'h7FFF_FFFF);
      dma_evt = 32'h4000_0000; cyc(); dma_evt = '0;
      chk("R10 urgent needs mask31", {31'b0, irq_out}, 0);

      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule